// File: doc/BRIEF.md
# Progressive Arrow Sign Sequencer

This block steps a five-lamp directional warning sign through a cumulative lighting pattern. Starting from a dark sign, each step adds lamps, first the pair at the tail of the arrow, then the middle pair, then the single lamp at the tip. After the full arrow it returns to dark and the cycle repeats. It is a Moore machine with two state bits, and the three lamp-group drives are decoded from those bits alone.

A master switch enables the display. While it is on, the sequence advances once on each clock edge where the tick input is high, so a slow strobe from elsewhere sets the blink rate. When the switch is off, the sign goes dark on the next edge whatever the tick is doing. A parameter can make every clock edge a step, with the tick input ignored. The lamp drives are registered, so they change only on clock edges.

Top module: `arrow_sign_seq`

## Requirements
- R1: While `rst` is high at a rising edge, the state becomes dark (code 00) and all three lamp outputs are 0 after that edge.
- R2: With `switch_on` and `tick` both high at a rising edge, the state advances one step along dark (00) → tail pair (01) → tail and middle (10) → full arrow (11). The outputs `{lamp_tail, lamp_mid, lamp_tip}` show 000, 100, 110 and 111 for these states.
- R3: From the full-arrow state, a step returns to dark. The pattern repeats for as long as the switch stays on.
- R4: With `switch_on` high and `tick` low at a rising edge, the state and all lamp outputs hold their values.
- R5: With `switch_on` low at a rising edge, the state becomes dark whatever the state and `tick` are. The switch wins over a tick in the same cycle.
- R6: `lamp_tail` (lamps 1 and 2) is 1 in every state except dark (00).
- R7: `lamp_mid` (lamps 3 and 4) is 1 exactly when state bit 1 is set (states 10 and 11).
- R8: `lamp_tip` (lamp 5) is 1 only in the full-arrow state (11).
- R9: The lamp outputs are registered and depend only on the state. A change on `switch_on` or `tick` between edges leaves them unchanged until the next rising edge.
- R10: With parameter `USE_TICK` = 0, the sequence advances on every rising edge while the switch is on, and `tick` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| switch_on | input | 1 | Master display switch; low forces dark |
| tick | input | 1 | Step enable (used when USE_TICK = 1) |
| lamp_tail | output | 1 | Drive for lamps 1 and 2 |
| lamp_mid | output | 1 | Drive for lamps 3 and 4 |
| lamp_tip | output | 1 | Drive for lamp 5 |

## Verification
The two functions that can meet in one cycle are the step on a tick and the forced return to dark when the switch is off. The bench drives both in the same cycle, from each of the four states, with `tick` high. It judges the result by checking that the lamps read 000 after that single edge rather than the next pattern. A behavioural integer model, updated on every edge, is compared with the lamp outputs of a ticked instance and a free-running instance every cycle. Directed checks cover the hold with tick low and the lamps staying steady between edges after an input change.

// File: rtl/arrow_sign_pkg.sv
package arrow_sign_pkg;

  localparam int unsigned NUM_STEPS = 4;
  localparam int unsigned STATE_W   = $clog2(NUM_STEPS);

  typedef enum logic [STATE_W-1:0] {
    ST_DARK = 2'b00,
    ST_TAIL = 2'b01,
    ST_MID  = 2'b10,
    ST_FULL = 2'b11
  } sign_state_t;

  typedef struct packed {
    logic tail;
    logic mid;
    logic tip;
  } lamp_drive_t;

  // cumulative pattern: each state adds lamps to the previous one
  function automatic lamp_drive_t lamp_pattern(input sign_state_t st);
    lamp_drive_t d;
    d.tail = (st != ST_DARK);
    d.mid  = st[1];
    d.tip  = (st == ST_FULL);
    return d;
  endfunction

endpackage

// File: rtl/arrow_step_ctrl.sv
module arrow_step_ctrl
  import arrow_sign_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        sw_on,
  input  logic        step_en,
  output sign_state_t state_q,
  output sign_state_t state_nxt
);

  always_comb begin
    state_nxt = state_q;
    if (!sw_on) begin
      state_nxt = ST_DARK;
    end else if (step_en) begin
      state_nxt = sign_state_t'(state_q + 2'd1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_DARK;
    end else begin
      state_q <= state_nxt;
    end
  end

  AST_DARK_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    !sw_on |=> state_q == ST_DARK); // R5

  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (rst)
    (sw_on && !step_en) |=> $stable(state_q)); // R4

  AST_FULL_WRAPS: assert property (@(posedge clk) disable iff (rst)
    (sw_on && step_en && state_q == ST_FULL) |=> state_q == ST_DARK); // R3

  AST_DARK_TO_TAIL: assert property (@(posedge clk) disable iff (rst)
    (sw_on && step_en && state_q == ST_DARK) |=> state_q == ST_TAIL); // R2

endmodule

// File: rtl/arrow_lamp_decode.sv
module arrow_lamp_decode
  import arrow_sign_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  sign_state_t state_nxt,
  input  sign_state_t state_q,
  output lamp_drive_t lamp_q
);

  // registered from the next state so the lamps line up with the state register
  always_ff @(posedge clk) begin
    if (rst) begin
      lamp_q <= '0;
    end else begin
      lamp_q <= lamp_pattern(state_nxt);
    end
  end

  AST_TAIL_DARK: assert property (@(posedge clk) disable iff (rst)
    lamp_q.tail == (state_q != ST_DARK)); // R6

  AST_MID_BIT: assert property (@(posedge clk) disable iff (rst)
    lamp_q.mid == state_q[1]); // R7

  AST_TIP_FULL: assert property (@(posedge clk) disable iff (rst)
    lamp_q.tip |-> state_q == ST_FULL); // R8

  AST_LAMP_NEST: assert property (@(posedge clk) disable iff (rst)
    lamp_q.tip |-> (lamp_q.mid && lamp_q.tail)); // R2

  AST_RESET_DARK: assert property (@(posedge clk)
    $past(rst) |-> lamp_q == '0); // R1

endmodule

// File: rtl/arrow_sign_seq.sv
module arrow_sign_seq
  import arrow_sign_pkg::*;
#(
  parameter bit USE_TICK = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic switch_on,
  input  logic tick,
  output logic lamp_tail,
  output logic lamp_mid,
  output logic lamp_tip
);

  logic        step_en;
  sign_state_t state_q;
  sign_state_t state_nxt;
  lamp_drive_t lamp_q;

  generate
    if (USE_TICK) begin : g_ticked
      assign step_en = tick;
    end else begin : g_free
      assign step_en = 1'b1; // R10: tick not used
    end
  endgenerate

  arrow_step_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .sw_on     (switch_on),
    .step_en   (step_en),
    .state_q   (state_q),
    .state_nxt (state_nxt)
  );

  arrow_lamp_decode u_decode (
    .clk       (clk),
    .rst       (rst),
    .state_nxt (state_nxt),
    .state_q   (state_q),
    .lamp_q    (lamp_q)
  );

  assign lamp_tail = lamp_q.tail;
  assign lamp_mid  = lamp_q.mid;
  assign lamp_tip  = lamp_q.tip;

  AST_OUT_STABLE_OFF: assert property (@(posedge clk) disable iff (rst)
    (!switch_on && !lamp_tail) |=> !lamp_tail && !lamp_mid && !lamp_tip); // R9

endmodule

// File: tb/arrow_sign_seq_tb.sv
module arrow_sign_seq_tb_top;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst = 1'b1;
  logic sw  = 1'b0;
  logic tk  = 1'b0;
  logic t_tail, t_mid, t_tip;
  logic f_tail, f_mid, f_tip;

  int checks = 0;
  int errors = 0;
  bit chk_on = 1'b0;
  bit done   = 1'b0;
  int m_tick = 0;
  int m_free = 0;

  arrow_sign_seq #(.USE_TICK(1'b1)) dut_i (
    .clk(clk), .rst(rst), .switch_on(sw), .tick(tk),
    .lamp_tail(t_tail), .lamp_mid(t_mid), .lamp_tip(t_tip)
  );

  arrow_sign_seq #(.USE_TICK(1'b0)) dut_free_i (
    .clk(clk), .rst(rst), .switch_on(sw), .tick(tk),
    .lamp_tail(f_tail), .lamp_mid(f_mid), .lamp_tip(f_tip)
  );

  // behavioural reference: integer step count modulo four
  always @(posedge clk) begin
    if (rst || !sw) begin
      m_tick = 0;
      m_free = 0;
    end else begin
      if (tk) m_tick = (m_tick + 1) % 4;
      m_free = (m_free + 1) % 4;
    end
  end

  function automatic logic [2:0] pat(input int s);
    return {s != 0, s >= 2, s == 3};
  endfunction

  task automatic chk(input string tag, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: lamps actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (chk_on && !done) begin
      chk("R2 R6 R7 R8 model ticked", {t_tail, t_mid, t_tip}, pat(m_tick));
      chk("R10 model free", {f_tail, f_mid, f_tip}, pat(m_free));
    end
  end

  task automatic cyc(input logic s, input logic t);
    sw = s;
    tk = t;
    @(negedge clk);
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset", {t_tail, t_mid, t_tip}, 3'b000);
    chk("R1 reset free", {f_tail, f_mid, f_tip}, 3'b000);
    rst = 1'b0;
    chk_on = 1'b1;

    cyc(1, 1); chk("R2 step tail", {t_tail, t_mid, t_tip}, 3'b100);
    cyc(1, 1); chk("R2 step mid", {t_tail, t_mid, t_tip}, 3'b110);
    cyc(1, 1); chk("R2 step full", {t_tail, t_mid, t_tip}, 3'b111);
    cyc(1, 1); chk("R3 wrap dark", {t_tail, t_mid, t_tip}, 3'b000);
    cyc(1, 1); chk("R3 repeat tail", {t_tail, t_mid, t_tip}, 3'b100);

    for (int i = 0; i < 3; i++) begin
      cyc(1, 0); chk("R4 hold tick low", {t_tail, t_mid, t_tip}, 3'b100);
    end
    // free instance stepped 8 times since release: back to dark
    chk("R10 free ignores tick", {f_tail, f_mid, f_tip}, 3'b000);
    cyc(1, 0);
    chk("R10 free steps tick low", {f_tail, f_mid, f_tip}, 3'b100);
    chk("R4 ticked still held", {t_tail, t_mid, t_tip}, 3'b100);

    // switch off in every state, colliding with a tick
    for (int s = 0; s < 4; s++) begin
      cyc(0, 0);
      for (int k = 0; k < s; k++) cyc(1, 1);
      chk("R5 reach state", {t_tail, t_mid, t_tip}, pat(s));
      cyc(0, 1);
      chk("R5 off beats tick", {t_tail, t_mid, t_tip}, 3'b000);
    end
    cyc(1, 1); cyc(1, 1); cyc(1, 1);
    cyc(0, 0);
    chk("R5 off tick low", {t_tail, t_mid, t_tip}, 3'b000);

    // registered outputs: input change between edges has no visible effect
    cyc(1, 1); cyc(1, 1);
    sw = 1'b0;
    tk = 1'b1;
    #3;
    chk("R9 steady between edges", {t_tail, t_mid, t_tip}, 3'b110);
    @(negedge clk);
    chk("R9 change after edge", {t_tail, t_mid, t_tip}, 3'b000);

    // several full cycles with an irregular tick
    for (int i = 0; i < 30; i++) cyc(1, (i % 3) != 0);
    chk("R3 after long run", {t_tail, t_mid, t_tip}, pat(m_tick));

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

endmodule